// File: doc/BRIEF.md
# Unpacked Floating-Point Adder

This block adds two floating-point operands that have already been unpacked into a class code, a sign, a signed exponent and a fixed-point mantissa. By default the mantissa has two integer bits and 64 fraction bits. Subtraction uses the same path: a `sub` input inverts the sign of the second operand before any other step. The result is also unpacked and unrounded. It carries a sticky bit for a later rounding stage and two exception flags. All outputs are registered, so a result appears one clock after its operands.

Inside, the operands are first ordered by class weight. Special classes are then resolved: NaN, infinity and zeros. For two ordinary numbers, the smaller-exponent operand is aligned and the magnitudes are added or subtracted. A subtraction always computes first-minus-second. A wrong-way result is detected from the borrow and fixed by negation, so no magnitude comparator sits ahead of the subtractor. The result is then renormalised after carry-out or cancellation. The rounding-mode input only affects the sign of zero results.

Top module: `fpadd_core`

## Requirements
- R1: Class codes are ZERO=0, NUM=1, INF=2, QNAN=3, SNAN=4 (codes 5 to 7 are not used). The operand with the larger code becomes the second operand, and on equal codes the original second operand stays second. For example, a QNAN first and an SNAN second yields the SNAN, and an SNAN first and a QNAN second also yields the SNAN.
- R2: When the second operand after ordering is a NaN, the result is that operand unchanged and `flag_nan` is 1.
- R3: If infinities of opposite effective sign are added, the result is the default NaN: class QNAN, sign 0, exponent 0, mantissa with the unit bit and the top fraction bit set. `flag_inf_inv` is also 1. Any other sum involving an infinity returns the infinity operand.
- R4: If both operands are zero, the result is the second zero with sign equal to the AND of both signs. Under rounding mode 2'b11 (toward minus infinity) the sign is the OR of both signs. Rounding codes are 00 nearest, 01 toward zero, 10 up, 11 down.
- R5: If exactly one operand is zero and the other is a number, the result is the number unchanged, with sticky 0.
- R6: The operand with the smaller exponent is shifted right by the exponent difference. The shift saturates at the mantissa width. Any 1 bits shifted out set `r_sticky`, and the result takes the larger exponent.
- R7: For equal effective signs the mantissas are added. If the sum is 2 or more, it is shifted right one place, the lost bit is ORed into sticky, and the exponent is incremented.
- R8: For opposite signs the result is first minus second, with the aligned sticky used as a borrow. An exact zero gives class ZERO, exponent 0, mantissa 0 and sign 1 only under rounding mode 2'b11.
- R9: A negative difference is negated, and the result takes the second operand's effective sign.
- R10: A nonzero difference below 1 is shifted left, with zeros entering, until the unit bit (bit 64 by default) is set. The exponent is reduced by the shift count.
- R11: `sub`=1 inverts the second operand's sign before ordering and all later steps.
- R12: Outputs are registered one cycle after the inputs. While `rst` is high they are cleared: class ZERO, all fields 0, flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_cls | input | 3 | First operand class code |
| a_sign | input | 1 | First operand sign |
| a_exp | input | EXP_W (16) | First operand exponent, signed |
| a_mant | input | MANT_W (66) | First operand mantissa, unit at bit FRAC_W |
| b_cls | input | 3 | Second operand class code |
| b_sign | input | 1 | Second operand sign |
| b_exp | input | EXP_W (16) | Second operand exponent, signed |
| b_mant | input | MANT_W (66) | Second operand mantissa |
| sub | input | 1 | Invert second operand sign (subtract) |
| rmode | input | 2 | Rounding mode code |
| r_cls | output | 3 | Result class code |
| r_sign | output | 1 | Result sign |
| r_exp | output | EXP_W (16) | Result exponent, signed |
| r_mant | output | MANT_W (66) | Result mantissa, unrounded |
| r_sticky | output | 1 | OR of all discarded bits |
| flag_nan | output | 1 | NaN operand propagated |
| flag_inf_inv | output | 1 | Infinity minus infinity |

## Verification
Alignment and subtraction can interact in one result. When the exponent gap saturates the shifter, every bit of the smaller operand becomes sticky. That sticky then acts as the borrow of an opposite-sign subtraction, leaving the larger mantissa reduced by one unit in the last place.

The bench provokes this with a directed gap of 100 and with random gaps of up to about 400. Each result is judged against a bench model that shifts one bit at a time and decides the result sign by comparing magnitudes. A second pairing is a one-ulp cancellation at equal exponents. There, negation and a 64-place normalisation happen in the same cycle, and both sign and exponent are checked.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
    localparam int FRAC_W = 64;
    localparam int INT_W  = 2;
    localparam int EXP_W  = 16;
    localparam int MANT_W = INT_W + FRAC_W;
    localparam int SH_W   = $clog2(MANT_W + 1);

    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_NUM  = 3'd1,
        CLS_INF  = 3'd2,
        CLS_QNAN = 3'd3,
        CLS_SNAN = 3'd4
    } fp_cls_e;

    typedef logic [MANT_W-1:0]        mant_t;
    typedef logic signed [EXP_W-1:0]  exp_t;

    typedef struct packed {
        fp_cls_e cls;
        logic    sign;
        exp_t    exp;
        mant_t   mant;
    } fp_op_t;

    localparam logic [1:0] RM_DOWN = 2'b11;
    localparam mant_t      UNIT    = mant_t'(1) << FRAC_W;
    localparam fp_op_t     DEF_NAN = '{cls: CLS_QNAN, sign: 1'b0, exp: '0,
                                       mant: UNIT | (UNIT >> 1)};

    function automatic logic is_nan(fp_cls_e c);
        return (c == CLS_QNAN) || (c == CLS_SNAN);
    endfunction

    // zeros counted from the unit position downward
    function automatic logic [SH_W-1:0] lead_zeros(mant_t m);
        logic [SH_W-1:0] n;
        logic            hit;
        n   = '0;
        hit = 1'b0;
        for (int i = FRAC_W; i >= 0; i--) begin
            if (!hit) begin
                if (m[i]) hit = 1'b1;
                else      n   = n + 1'b1;
            end
        end
        return n;
    endfunction
endpackage

// File: rtl/fpadd_order.sv
module fpadd_order
    import fpadd_pkg::*;
(
    input  fp_op_t a,
    input  fp_op_t b,
    input  logic   sub,
    output fp_op_t x,
    output fp_op_t y
);
    fp_op_t b_eff;

    always_comb begin
        b_eff      = b;
        b_eff.sign = b.sign ^ sub;
        // heavier class goes second; ties keep the given order
        if (a.cls > b_eff.cls) begin
            x = b_eff;
            y = a;
        end else begin
            x = a;
            y = b_eff;
        end
    end
endmodule

// File: rtl/fpadd_align.sv
module fpadd_align
    import fpadd_pkg::*;
(
    input  fp_op_t x,
    input  fp_op_t y,
    output logic   hi_sign,
    output exp_t   hi_exp,
    output mant_t  hi_mant,
    output logic   lo_sign,
    output mant_t  lo_mant,
    output logic   sticky
);
    logic                  swap;
    logic [EXP_W:0]        gap;
    logic [SH_W-1:0]       sh;
    mant_t                 lo_raw;
    mant_t                 lost_mask;

    always_comb begin
        swap    = x.exp < y.exp;
        hi_sign = swap ? y.sign : x.sign;
        hi_exp  = swap ? y.exp  : x.exp;
        hi_mant = swap ? y.mant : x.mant;
        lo_sign = swap ? x.sign : y.sign;
        lo_raw  = swap ? x.mant : y.mant;
        gap     = {hi_exp[EXP_W-1], hi_exp} - {(swap ? x.exp[EXP_W-1] : y.exp[EXP_W-1]),
                                              (swap ? x.exp : y.exp)};
        if (gap >= (EXP_W+1)'(MANT_W)) sh = SH_W'(MANT_W);
        else                           sh = gap[SH_W-1:0];
        lo_mant   = lo_raw >> sh;
        lost_mask = ~(~mant_t'(0) << sh);
        sticky    = |(lo_raw & lost_mask);
    end
endmodule

// File: rtl/fpadd_mag.sv
module fpadd_mag
    import fpadd_pkg::*;
(
    input  logic       hi_sign,
    input  exp_t       hi_exp,
    input  mant_t      hi_mant,
    input  logic       lo_sign,
    input  mant_t      lo_mant,
    input  logic       sticky_in,
    input  logic [1:0] rmode,
    output fp_op_t     res,
    output logic       sticky_out
);
    localparam int TWO_POS = FRAC_W + 1;

    mant_t           sum;
    logic [MANT_W:0] dif;
    mant_t           mag;
    logic [SH_W-1:0] lz;

    always_comb begin
        res        = '{cls: CLS_NUM, sign: hi_sign, exp: hi_exp, mant: '0};
        sticky_out = sticky_in;
        sum        = hi_mant + lo_mant;
        dif        = {1'b0, hi_mant} - {1'b0, lo_mant} - (MANT_W+1)'(sticky_in);
        mag        = dif[MANT_W] ? (~dif[MANT_W-1:0] + mant_t'(1)) : dif[MANT_W-1:0];
        lz         = lead_zeros(mag);
        if (hi_sign == lo_sign) begin
            if (sum[TWO_POS]) begin
                res.mant   = sum >> 1;
                res.exp    = hi_exp + exp_t'(1);
                sticky_out = sticky_in | sum[0];
            end else begin
                res.mant = sum;
            end
        end else if (dif == '0) begin
            res = '{cls: CLS_ZERO, sign: (rmode == RM_DOWN), exp: '0, mant: '0};
        end else begin
            if (dif[MANT_W]) res.sign = lo_sign;
            res.mant = mag << lz;
            res.exp  = hi_exp - exp_t'(lz);
        end
    end
endmodule

// File: rtl/fpadd_core.sv
module fpadd_core
    import fpadd_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [2:0]              a_cls,
    input  logic                    a_sign,
    input  logic signed [EXP_W-1:0] a_exp,
    input  logic [MANT_W-1:0]       a_mant,
    input  logic [2:0]              b_cls,
    input  logic                    b_sign,
    input  logic signed [EXP_W-1:0] b_exp,
    input  logic [MANT_W-1:0]       b_mant,
    input  logic                    sub,
    input  logic [1:0]              rmode,
    output logic [2:0]              r_cls,
    output logic                    r_sign,
    output logic signed [EXP_W-1:0] r_exp,
    output logic [MANT_W-1:0]       r_mant,
    output logic                    r_sticky,
    output logic                    flag_nan,
    output logic                    flag_inf_inv
);
    fp_op_t a_op, b_op, x, y, num_res, nxt, r_q;
    logic   hi_sign, lo_sign, al_sticky, num_sticky;
    exp_t   hi_exp;
    mant_t  hi_mant, lo_mant;
    logic   nxt_st, nxt_fn, nxt_fi;

    always_comb begin
        a_op = '{cls: fp_cls_e'(a_cls), sign: a_sign, exp: a_exp, mant: a_mant};
        b_op = '{cls: fp_cls_e'(b_cls), sign: b_sign, exp: b_exp, mant: b_mant};
    end

    fpadd_order u_order (.a(a_op), .b(b_op), .sub(sub), .x(x), .y(y));

    fpadd_align u_align (
        .x(x), .y(y),
        .hi_sign(hi_sign), .hi_exp(hi_exp), .hi_mant(hi_mant),
        .lo_sign(lo_sign), .lo_mant(lo_mant), .sticky(al_sticky)
    );

    fpadd_mag u_mag (
        .hi_sign(hi_sign), .hi_exp(hi_exp), .hi_mant(hi_mant),
        .lo_sign(lo_sign), .lo_mant(lo_mant), .sticky_in(al_sticky),
        .rmode(rmode), .res(num_res), .sticky_out(num_sticky)
    );

    // special classes resolved in priority order
    always_comb begin
        nxt    = y;
        nxt_st = 1'b0;
        nxt_fn = 1'b0;
        nxt_fi = 1'b0;
        if (is_nan(y.cls)) begin
            nxt_fn = 1'b1;
        end else if (y.cls == CLS_INF) begin
            if (x.cls == CLS_INF && x.sign != y.sign) begin
                nxt    = DEF_NAN;
                nxt_fi = 1'b1;
            end
        end else if (y.cls == CLS_ZERO) begin
            nxt.sign = (rmode == RM_DOWN) ? (x.sign | y.sign) : (x.sign & y.sign);
        end else if (x.cls != CLS_ZERO) begin
            nxt    = num_res;
            nxt_st = num_sticky;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q          <= '0;
            r_sticky     <= 1'b0;
            flag_nan     <= 1'b0;
            flag_inf_inv <= 1'b0;
        end else begin
            r_q          <= nxt;
            r_sticky     <= nxt_st;
            flag_nan     <= nxt_fn;
            flag_inf_inv <= nxt_fi;
        end
    end

    assign r_cls  = r_q.cls;
    assign r_sign = r_q.sign;
    assign r_exp  = r_q.exp;
    assign r_mant = r_q.mant;

    p_nan_prop_r2: assert property (@(posedge clk) disable iff (rst)
        flag_nan |-> ((r_cls == CLS_QNAN || r_cls == CLS_SNAN) &&
                      $past(a_cls == CLS_QNAN || a_cls == CLS_SNAN ||
                            b_cls == CLS_QNAN || b_cls == CLS_SNAN)));

    p_inf_pair_r3: assert property (@(posedge clk) disable iff (rst)
        flag_inf_inv |-> ($past(a_cls == CLS_INF && b_cls == CLS_INF) && !flag_nan));

    p_sticky_num_r6: assert property (@(posedge clk) disable iff (rst)
        r_sticky |-> (r_cls == CLS_NUM));

    p_cancel_sign_r8: assert property (@(posedge clk) disable iff (rst)
        (r_cls == CLS_ZERO && $past(a_cls == CLS_NUM && b_cls == CLS_NUM))
        |-> (r_sign == ($past(rmode) == RM_DOWN)));

    p_normalised_r10: assert property (@(posedge clk) disable iff (rst)
        (r_cls == CLS_NUM && $past(a_cls == CLS_NUM && b_cls == CLS_NUM))
        |-> (r_mant[FRAC_W] && !r_mant[MANT_W-1]));
endmodule

// File: tb/test_fpadd_core.sv
`timescale 1ns/1ps
module test_fpadd_core;
    import fpadd_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] a_cls = '0, b_cls = '0;
    logic a_sign = 1'b0, b_sign = 1'b0, sub = 1'b0;
    logic signed [EXP_W-1:0] a_exp = '0, b_exp = '0;
    logic [MANT_W-1:0] a_mant = '0, b_mant = '0;
    logic [1:0] rmode = '0;
    logic [2:0] r_cls;
    logic r_sign, r_sticky, flag_nan, flag_inf_inv;
    logic signed [EXP_W-1:0] r_exp;
    logic [MANT_W-1:0] r_mant;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    fpadd_core i_fpadd_core (
        .clk(clk), .rst(rst),
        .a_cls(a_cls), .a_sign(a_sign), .a_exp(a_exp), .a_mant(a_mant),
        .b_cls(b_cls), .b_sign(b_sign), .b_exp(b_exp), .b_mant(b_mant),
        .sub(sub), .rmode(rmode),
        .r_cls(r_cls), .r_sign(r_sign), .r_exp(r_exp), .r_mant(r_mant),
        .r_sticky(r_sticky), .flag_nan(flag_nan), .flag_inf_inv(flag_inf_inv)
    );

    localparam mant_t ONE  = mant_t'(1) << FRAC_W;
    localparam mant_t HALF = ONE >> 1;

    function automatic fp_op_t mk(fp_cls_e c, logic s, int e, mant_t m);
        return '{cls: c, sign: s, exp: exp_t'(e), mant: m};
    endfunction

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual hung expected finish");
            finish_run();
        end
    end

    task automatic apply(fp_op_t a, fp_op_t b, logic s, logic [1:0] rm);
        @(negedge clk);
        a_cls = a.cls; a_sign = a.sign; a_exp = a.exp; a_mant = a.mant;
        b_cls = b.cls; b_sign = b.sign; b_exp = b.exp; b_mant = b.mant;
        sub = s; rmode = rm;
        @(negedge clk);
    endtask

    task automatic check(string tag, fp_op_t e, logic est, logic efn, logic efi);
        logic [MANT_W+EXP_W+7:0] act, exv;
        act = {r_cls, r_sign, r_exp, r_mant, r_sticky, flag_nan, flag_inf_inv};
        exv = {e.cls, e.sign, e.exp, e.mant, est, efn, efi};
        n_run = n_run + 1;
        if (act !== exv) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual cls=%0d s=%0b e=%0d m=%h st=%0b fn=%0b fi=%0b expected cls=%0d s=%0b e=%0d m=%h st=%0b fn=%0b fi=%0b",
                     tag, r_cls, r_sign, r_exp, r_mant, r_sticky, flag_nan, flag_inf_inv,
                     e.cls, e.sign, e.exp, e.mant, est, efn, efi);
        end
    endtask

    // bench model, built from the requirement text
    function automatic void model(input fp_op_t a_i, input fp_op_t b_i, input logic sb,
                                  input logic [1:0] rm, output fp_op_t r, output logic st,
                                  output logic fn, output logic fi, output string tag);
        fp_op_t p, q, t;
        int ep, eq, d;
        logic [MANT_W+1:0] mp, mq, acc;
        logic rs;
        p = a_i; q = b_i; q.sign = q.sign ^ sb;
        st = 0; fn = 0; fi = 0; tag = "R1";
        if (int'(p.cls) > int'(q.cls)) begin t = p; p = q; q = t; end
        r = q;
        if (q.cls == CLS_QNAN || q.cls == CLS_SNAN) begin fn = 1; tag = "R2"; return; end
        if (q.cls == CLS_INF) begin
            tag = "R3";
            if (p.cls == CLS_INF && p.sign != q.sign) begin
                r = mk(CLS_QNAN, 1'b0, 0, ONE | HALF); fi = 1;
            end
            return;
        end
        if (q.cls == CLS_ZERO) begin
            r.sign = (rm == 2'b11) ? (p.sign | q.sign) : (p.sign & q.sign);
            tag = "R4"; return;
        end
        if (p.cls == CLS_ZERO) begin tag = "R5"; return; end
        ep = int'(p.exp); eq = int'(q.exp);
        if (ep < eq) begin t = p; p = q; q = t; d = ep; ep = eq; eq = d; end
        d  = ep - eq;
        mp = {2'b00, p.mant};
        mq = {2'b00, q.mant};
        for (int i = 0; i < d && i < MANT_W + 2; i++) begin
            st = st | mq[0];
            mq = mq >> 1;
        end
        tag = (d != 0) ? "R6" : "R7";
        if (p.sign == q.sign) begin
            acc = mp + mq; rs = p.sign;
            if (acc[FRAC_W+1]) begin st = st | acc[0]; acc = acc >> 1; ep++; tag = "R7"; end
        end else begin
            if (mp >= mq + (MANT_W+2)'(st)) begin
                acc = mp - mq - (MANT_W+2)'(st); rs = p.sign; tag = "R10";
            end else begin
                acc = mq + (MANT_W+2)'(st) - mp; rs = q.sign; tag = "R9";
            end
            if (acc == 0) begin r = mk(CLS_ZERO, rm == 2'b11, 0, '0); tag = "R8"; return; end
            while (!acc[FRAC_W]) begin acc = acc << 1; ep--; end
        end
        r = mk(CLS_NUM, rs, ep, acc[MANT_W-1:0]);
    endfunction

    function automatic fp_op_t rnd_op();
        int k;
        int e;
        mant_t m;
        k = $urandom % 16;
        e = (($urandom % 8) == 0) ? (int'($urandom % 400) - 200) : (int'($urandom % 64) - 32);
        m = {2'b01, $urandom, $urandom};
        if ($urandom % 3 == 0) m[FRAC_W-1:24] = '0;
        if (k < 10)       return mk(CLS_NUM, 1'($urandom), e, m);
        else if (k < 12)  return mk(CLS_ZERO, 1'($urandom), e, '0);
        else if (k < 14)  return mk(CLS_INF, 1'($urandom), e, '0);
        else if (k == 14) return mk(CLS_QNAN, 1'($urandom), e, m);
        else              return mk(CLS_SNAN, 1'($urandom), e, m);
    endfunction

    initial begin
        fp_op_t ea, eb, er;
        logic est, efn, efi;
        string tg;
        void'($urandom(32'h5eed_0042));

        // R12: reset state
        repeat (3) @(negedge clk);
        check("R12 reset", mk(CLS_ZERO, 0, 0, '0), 0, 0, 0);
        @(negedge clk); rst = 1'b0;

        // R1: class ordering among NaNs and infinity over number
        apply(mk(CLS_QNAN, 0, 1, ONE | 66'h5), mk(CLS_SNAN, 1, 2, ONE | 66'h9), 0, 0);
        check("R1 q-then-s", mk(CLS_SNAN, 1, 2, ONE | 66'h9), 0, 1, 0);
        apply(mk(CLS_SNAN, 0, 3, ONE | 66'h7), mk(CLS_QNAN, 1, 4, ONE | 66'h3), 0, 0);
        check("R1 s-then-q", mk(CLS_SNAN, 0, 3, ONE | 66'h7), 0, 1, 0);
        apply(mk(CLS_INF, 1, 0, '0), mk(CLS_NUM, 0, 5, ONE), 0, 0);
        check("R1 inf over num", mk(CLS_INF, 1, 0, '0), 0, 0, 0);

        // R2: NaN propagation
        apply(mk(CLS_NUM, 0, 9, ONE), mk(CLS_QNAN, 0, 7, ONE | 66'h33), 0, 2);
        check("R2 qnan", mk(CLS_QNAN, 0, 7, ONE | 66'h33), 0, 1, 0);

        // R3 and R11: infinities
        apply(mk(CLS_INF, 0, 0, '0), mk(CLS_INF, 1, 0, '0), 0, 0);
        check("R3 inf-inf", mk(CLS_QNAN, 0, 0, ONE | HALF), 0, 0, 1);
        apply(mk(CLS_INF, 1, 0, '0), mk(CLS_INF, 1, 0, '0), 0, 0);
        check("R3 inf+inf", mk(CLS_INF, 1, 0, '0), 0, 0, 0);
        apply(mk(CLS_INF, 0, 0, '0), mk(CLS_INF, 0, 0, '0), 1, 0);
        check("R11 inf sub inf", mk(CLS_QNAN, 0, 0, ONE | HALF), 0, 0, 1);

        // R4: zero signs
        apply(mk(CLS_ZERO, 1, 0, '0), mk(CLS_ZERO, 0, 0, '0), 0, 2'b00);
        check("R4 mixed near", mk(CLS_ZERO, 0, 0, '0), 0, 0, 0);
        apply(mk(CLS_ZERO, 1, 0, '0), mk(CLS_ZERO, 0, 0, '0), 0, 2'b11);
        check("R4 mixed down", mk(CLS_ZERO, 1, 0, '0), 0, 0, 0);
        apply(mk(CLS_ZERO, 1, 0, '0), mk(CLS_ZERO, 1, 0, '0), 0, 2'b01);
        check("R4 both neg", mk(CLS_ZERO, 1, 0, '0), 0, 0, 0);

        // R5: zero with a number
        apply(mk(CLS_ZERO, 1, 0, '0), mk(CLS_NUM, 1, -7, ONE | 66'h1234), 0, 0);
        check("R5 zero first", mk(CLS_NUM, 1, -7, ONE | 66'h1234), 0, 0, 0);
        apply(mk(CLS_NUM, 0, 12, ONE | HALF), mk(CLS_ZERO, 0, 0, '0), 1, 3);
        check("R5 zero second", mk(CLS_NUM, 0, 12, ONE | HALF), 0, 0, 0);

        // R6: alignment sticky and saturation
        apply(mk(CLS_NUM, 0, 3, ONE), mk(CLS_NUM, 0, 0, ONE | 66'h1), 0, 0);
        check("R6 shift3", mk(CLS_NUM, 0, 3, ONE | (ONE >> 3)), 1, 0, 0);
        apply(mk(CLS_NUM, 1, 100, ONE | HALF), mk(CLS_NUM, 0, 0, ONE), 0, 0);
        check("R6 saturate borrow", mk(CLS_NUM, 1, 100, (ONE | HALF) - 66'h1), 1, 0, 0);

        // R7: carry out
        apply(mk(CLS_NUM, 0, 0, ONE | HALF), mk(CLS_NUM, 0, 0, ONE | HALF), 0, 0);
        check("R7 carry", mk(CLS_NUM, 0, 1, ONE | HALF), 0, 0, 0);

        // R8: exact cancellation
        apply(mk(CLS_NUM, 0, 5, ONE | (HALF >> 1)), mk(CLS_NUM, 0, 5, ONE | (HALF >> 1)), 1, 2'b00);
        check("R8 cancel near", mk(CLS_ZERO, 0, 0, '0), 0, 0, 0);
        apply(mk(CLS_NUM, 1, 5, ONE), mk(CLS_NUM, 0, 5, ONE), 0, 2'b11);
        check("R8 cancel down", mk(CLS_ZERO, 1, 0, '0), 0, 0, 0);

        // R9: wrong-way difference
        apply(mk(CLS_NUM, 0, 0, ONE), mk(CLS_NUM, 0, 0, ONE | HALF), 1, 0);
        check("R9 negate", mk(CLS_NUM, 1, -1, ONE), 0, 0, 0);
        apply(mk(CLS_NUM, 0, 0, ONE), mk(CLS_NUM, 0, 0, ONE | 66'h1), 1, 0);
        check("R9 one ulp", mk(CLS_NUM, 1, -64, ONE), 0, 0, 0);

        // R10: normalisation without negation
        apply(mk(CLS_NUM, 0, 0, ONE | HALF | (HALF >> 1)), mk(CLS_NUM, 1, 0, ONE | HALF), 0, 0);
        check("R10 left shift", mk(CLS_NUM, 0, -2, ONE), 0, 0, 0);

        // random mix against the bench model
        for (int i = 0; i < 4000; i++) begin
            logic sb;
            logic [1:0] rm;
            ea = rnd_op();
            eb = rnd_op();
            if ($urandom % 5 == 0) begin
                eb = ea;
                eb.sign = 1'($urandom);
                if ($urandom % 2 == 0) eb.mant[3:0] = 4'($urandom);
            end
            sb = 1'($urandom);
            rm = 2'($urandom);
            model(ea, eb, sb, rm, er, est, efn, efi, tg);
            apply(ea, eb, sb, rm);
            check(tg, er, est, efn, efi);
        end

        finish_run();
    end
endmodule